// File: doc/BRIEF.md
# CAN Edge Delay Analyzer

This block watches the receive and transmit lines of one CAN node and measures, in module clock cycles, the distance between two edges chosen by a mode field. It serves bit-timing calibration. It can report the length of a dominant stretch seen on the bus. It can report the loop delay from a transmitted dominant or recessive edge to its echo on the receive line. It can also report how far a synchronizing dominant edge lies from the last sample point. The node's bit-timing logic supplies the sample-point and sync-qualify strobes. The block only observes. It never drives the bus.

The raw receive line first passes through a two-flop synchronizer. Every receive edge is therefore seen two cycles late, and both loop-delay results include those two cycles. A saturating counter restarts at the reference event of the active mode. When the matching end event arrives, the counter value goes into a capture register and a one-cycle valid strobe is raised. The capture register holds its value until the next completed measurement, so software may read it at any time.

Top module: `edge_delay_meter`

## Requirements
- R1: The receive line is resynchronized through two flops. A loop-delay result equals the bus delay plus 2, so zero bus delay reads 2.
- R2: Mode code 3'b001 (dominant stretch): a falling receive edge (1 to 0) starts the count. The next rising receive edge captures the number of cycles between the two edges.
- R3: Mode code 3'b010 (dominant loop delay): a falling edge on tx_line starts the count. The next falling receive edge captures it.
- R4: Mode code 3'b011 (recessive loop delay): a rising edge on tx_line starts the count. The next rising receive edge captures it.
- R5: Mode code 3'b100 (sync distance): a sample_pt pulse starts the count. A falling receive edge that is detected in a cycle where sync_qual is high captures it. A falling edge without sync_qual captures nothing and leaves cap_value unchanged.
- R6: Codes 3'b000 and 3'b101 to 3'b111 disable measurement. No cap_valid is raised and cap_value does not change.
- R7: Any change of mode_sel discards a started measurement. An end event after the change, even with the original code restored, captures nothing.
- R8: The counter saturates at 2^CNT_W-1 (255 by default) and does not wrap. Every captured value is nonzero.
- R9: cap_valid is high for exactly one cycle per capture. cap_value changes only together with cap_valid and holds in between.
- R10: After reset, cap_value is 0 and cap_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Unsynchronized CAN receive line (0 = dominant) |
| tx_line | input | 1 | Node transmit line, synchronous to clk |
| sample_pt | input | 1 | One-cycle strobe at the node's sample point |
| sync_qual | input | 1 | High in the cycle a detected dominant edge qualifies for synchronization |
| mode_sel | input | 3 | Measurement select code |
| cap_value | output | CNT_W | Last captured cycle count |
| cap_valid | output | 1 | One-cycle strobe on a new capture |

## Verification
The bench changes inputs on the falling clock edge. A measurement whose end event is a receive edge driven at the input in step k raises cap_valid at step k+3: two synchronizer flops, then one capture register. A transmit or sample_pt reference driven at step 0 makes the counter read 1 at step 1. The loop-delay results are therefore the bus delay plus 2, the dominant stretch equals its width, and the sync distance equals the edge offset plus 2. Each task checks that cap_valid is still low one step before the due step, that the value is right at the due step, and that the strobe is gone one step later. Windows in which nothing may be captured are checked step by step against the last expected value.

// File: rtl/edm_pkg.sv
package edm_pkg;

    typedef enum logic [2:0] {
        MODE_OFF      = 3'b000,
        MODE_DOM_SPAN = 3'b001,
        MODE_DOM_LOOP = 3'b010,
        MODE_REC_LOOP = 3'b011,
        MODE_SYNC_SP  = 3'b100
    } edm_mode_e;

    typedef struct packed {
        logic ref_evt;
        logic end_evt;
        logic keep_arm;
        logic mode_ok;
    } edm_evt_t;

endpackage

// File: rtl/edm_edge_det.sv
module edm_edge_det #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic lvl;
    logic prev_d, prev_q;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = din;
        end else begin : g_sync
            logic [STAGES-1:0] sh_d, sh_q;

            always_comb begin
                sh_d[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    sh_d[i] = sh_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{IDLE}};
                else        sh_q <= sh_d;
            end

            assign lvl = sh_q[STAGES-1];
        end
    endgenerate

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/edm_event_sel.sv
module edm_event_sel
    import edm_pkg::*;
(
    input  logic           [2:0] mode,
    input  logic                 rx_rise,
    input  logic                 rx_fall,
    input  logic                 tx_rise,
    input  logic                 tx_fall,
    input  logic                 sample_pt,
    input  logic                 sync_qual,
    output edm_evt_t             evt
);
    always_comb begin
        evt = '0;
        case (edm_mode_e'(mode))
            MODE_DOM_SPAN: begin
                evt.ref_evt = rx_fall;
                evt.end_evt = rx_rise;
                evt.mode_ok = 1'b1;
            end
            MODE_DOM_LOOP: begin
                evt.ref_evt = tx_fall;
                evt.end_evt = rx_fall;
                evt.mode_ok = 1'b1;
            end
            MODE_REC_LOOP: begin
                evt.ref_evt = tx_rise;
                evt.end_evt = rx_rise;
                evt.mode_ok = 1'b1;
            end
            MODE_SYNC_SP: begin
                evt.ref_evt  = sample_pt;
                evt.end_evt  = rx_fall & sync_qual;
                evt.keep_arm = 1'b1;
                evt.mode_ok  = 1'b1;
            end
            default: evt = '0;
        endcase
    end
endmodule

// File: rtl/edm_sat_counter.sv
module edm_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_evt,
    input  logic             end_evt,
    input  logic             keep_arm,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = st_q.armed & end_evt & ~clr;
        if (clr) begin
            st_d = '0;
        end else if (ref_evt) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CNT_ONE;
        end else begin
            if (done && !keep_arm) st_d.armed = 1'b0;
            if (st_q.armed && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/edge_delay_meter.sv
module edge_delay_meter
    import edm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_raw,
    input  logic             tx_line,
    input  logic             sample_pt,
    input  logic             sync_qual,
    input  logic [2:0]       mode_sel,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_valid
);
    typedef struct packed {
        logic [2:0]       mode;
        logic [CNT_W-1:0] val;
        logic             vld;
    } cap_state_t;

    cap_state_t       cs_d, cs_q;
    logic             rx_rise, rx_fall, tx_rise, tx_fall;
    edm_evt_t         evt;
    logic             clr;
    logic             done;
    logic [CNT_W-1:0] count;

    edm_edge_det #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rx_edge (
        .clk(clk), .rst_n(rst_n), .din(rx_raw), .rise(rx_rise), .fall(rx_fall)
    );

    edm_edge_det #(.STAGES(0), .IDLE(1'b1)) u_tx_edge (
        .clk(clk), .rst_n(rst_n), .din(tx_line), .rise(tx_rise), .fall(tx_fall)
    );

    edm_event_sel u_sel (
        .mode(mode_sel), .rx_rise(rx_rise), .rx_fall(rx_fall),
        .tx_rise(tx_rise), .tx_fall(tx_fall),
        .sample_pt(sample_pt), .sync_qual(sync_qual), .evt(evt)
    );

    edm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ref_evt(evt.ref_evt), .end_evt(evt.end_evt), .keep_arm(evt.keep_arm),
        .count(count), .done(done)
    );

    always_comb begin
        clr       = (mode_sel != cs_q.mode) | ~evt.mode_ok;
        cs_d      = cs_q;
        cs_d.mode = mode_sel;
        cs_d.vld  = done;
        if (done) cs_d.val = count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign cap_value = cs_q.val;
    assign cap_valid = cs_q.vld;
endmodule

// File: rtl/edm_checker.sv
module edm_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_sel,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_valid
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);  // R9
    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> $stable(cap_value));  // R9
    AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_sel) == 3'b000) || ($past(mode_sel) > 3'b100)) |-> !cap_valid);  // R6
    AST_NONZERO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (cap_value != '0));  // R8
    AST_LOOP_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && (($past(mode_sel) == 3'b010) || ($past(mode_sel) == 3'b011)))
        |-> (cap_value >= CNT_W'(2)));  // R1
endmodule

bind edge_delay_meter edm_checker #(.CNT_W(CNT_W)) u_edm_checker (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .cap_value(cap_value), .cap_valid(cap_valid)
);

// File: tb/edge_delay_meter_tb_top.sv
module edge_delay_meter_tb_top;
    localparam int CNT_W   = 8;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_raw = 1'b1;
    logic             tx_line = 1'b1;
    logic             sample_pt = 1'b0;
    logic             sync_qual = 1'b0;
    logic [2:0]       mode_sel = 3'b000;
    logic [CNT_W-1:0] cap_value;
    logic             cap_valid;

    int checks = 0;
    int fails  = 0;
    int last_cap = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    edge_delay_meter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .tx_line(tx_line),
        .sample_pt(sample_pt), .sync_qual(sync_qual), .mode_sel(mode_sel),
        .cap_value(cap_value), .cap_valid(cap_valid)
    );

    function automatic int sat(input int v);
        return (v > CNT_MAX) ? CNT_MAX : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_none(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, int'(cap_valid), 0);
            chk(req, int'(cap_value), last_cap);
        end
    endtask

    // Capture due at step 'due'; strobe must be low before and after it.
    task automatic expect_capture(input int exp, input string req);
        chk(req, int'(cap_valid), 1);
        chk(req, int'(cap_value), exp);
        last_cap = exp;
        @(negedge clk);
        chk("R9", int'(cap_valid), 0);
        chk("R9", int'(cap_value), exp);
    endtask

    task automatic run_loop(input logic [2:0] m, input logic pol, input int d, input string req);
        mode_sel = m;
        tx_line  = ~pol;
        rx_raw   = ~pol;
        step(6);
        tx_line = pol;
        if (d == 0) rx_raw = pol;
        for (int i = 1; i <= d + 3; i++) begin
            @(negedge clk);
            if (i == d) rx_raw = pol;
            if (i == d + 2) chk(req, int'(cap_valid), 0);
        end
        expect_capture(sat(d + 2), req);
    endtask

    task automatic run_span(input int w, input string req);
        mode_sel = 3'b001;
        rx_raw   = 1'b1;
        step(6);
        rx_raw = 1'b0;
        for (int i = 1; i <= w + 3; i++) begin
            @(negedge clk);
            if (i == w) rx_raw = 1'b1;
            if (i == w + 2) chk(req, int'(cap_valid), 0);
        end
        expect_capture(sat(w), req);
    endtask

    task automatic run_sync(input int r, input bit qual, input string req);
        mode_sel  = 3'b100;
        rx_raw    = 1'b1;
        sample_pt = 1'b0;
        sync_qual = 1'b0;
        step(6);
        sample_pt = 1'b1;
        for (int i = 1; i <= r + 3; i++) begin
            @(negedge clk);
            if (i == 1) sample_pt = 1'b0;
            if (i == r) rx_raw = 1'b0;
            if (i == r + 2) begin
                chk(req, int'(cap_valid), 0);
                sync_qual = qual;
            end
            if (i == r + 3) sync_qual = 1'b0;
        end
        if (qual) expect_capture(sat(r + 2), req);
        else begin
            chk(req, int'(cap_valid), 0);
            chk(req, int'(cap_value), last_cap);
        end
        rx_raw = 1'b1;
        step(4);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        chk("R10", int'(cap_valid), 0);
        chk("R10", int'(cap_value), 0);
        rst_n = 1'b1;
        step(2);
        chk("R10", int'(cap_valid), 0);

        run_loop(3'b010, 1'b0, 0, "R1");
        run_loop(3'b010, 1'b0, 5, "R3");
        run_loop(3'b011, 1'b1, 3, "R4");
        run_loop(3'b011, 1'b1, 0, "R1");
        run_span(1, "R2");
        run_span(10, "R2");
        run_sync(1, 1'b1, "R5");
        run_sync(4, 1'b0, "R5");
        run_sync(7, 1'b1, "R5");
        run_loop(3'b010, 1'b0, 300, "R8");
        run_span(400, "R8");

        // R7: reference taken, mode toggled away and back, then end event.
        mode_sel = 3'b010; tx_line = 1'b1; rx_raw = 1'b1;
        step(6);
        tx_line = 1'b0;
        step(1); mode_sel = 3'b011;
        step(1); mode_sel = 3'b010;
        step(1); rx_raw = 1'b0;
        expect_none(8, "R7");
        tx_line = 1'b1; rx_raw = 1'b1;
        expect_none(5, "R7");

        // R6: disabled codes with every kind of event applied.
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            mode_sel = 3'(c);
            tx_line = 1'b1; rx_raw = 1'b1;
            step(4);
            sample_pt = 1'b1; tx_line = 1'b0; rx_raw = 1'b0;
            step(1); sample_pt = 1'b0;
            step(1); sync_qual = 1'b1;
            step(1); sync_qual = 1'b0;
            expect_none(6, "R6");
            tx_line = 1'b1; rx_raw = 1'b1;
            expect_none(5, "R6");
        end

        // Random mix of modes and delays.
        for (int k = 0; k < 40; k++) begin
            int sel = int'($urandom_range(0, 3));
            int d   = int'($urandom_range(0, 20));
            case (sel)
                0: run_loop(3'b010, 1'b0, d, "R3");
                1: run_loop(3'b011, 1'b1, d, "R4");
                2: run_span(d + 1, "R2");
                default: run_sync(d + 1, ($urandom_range(0, 1) == 1), "R5");
            endcase
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end
endmodule